// File: doc/BRIEF.md
# Two-Sided Doorbell Mailbox

This block lets two bus agents exchange short messages through registers. The agents are a requester side (A) and a host side (H). Each direction has its own channel. A channel holds a message of `N_WORDS` words; word 0 carries the request or event code. It also holds a small handshake state machine. The sender fills the words and raises a valid flag. The receiver reads the words through its own receive window and answers by writing an acknowledge. The sender then drops valid. That single action retires the whole handshake: the receiver's acknowledge clears first, and one cycle later the acknowledge the sender sees clears too.

Each side has a register port with the following parts:
- a write strobe;
- a shared address for reads and writes;
- a data word, where control registers use only the low byte;
- a combinational read bus.

Each side also has an interrupt enable register. It gates two one-cycle pulses:
- a receive pulse, when the peer posts a message;
- an acknowledge pulse, when the peer acknowledges this side's message.

Per-side address map, with default `N_WORDS`=4:

| Address | Register | Bits |
|---|---|---|
| 0..3 | transmit words (read/write) | — |
| 4..7 | receive words (read-only, the peer's transmit words) | — |
| 8 | transmit control | bit 0 valid (write), bit 1 acknowledge from the peer (read-only), bit 2 sticky overwrite error (write 1 to clear) |
| 9 | receive control | bit 0 peer valid (read-only), bit 1 acknowledge (write 1 to set) |
| 10 | interrupt enable | bit 0 receive, bit 1 acknowledge |

All other addresses read zero.

Each channel state machine has four states:
- `CH_IDLE`: valid 0, no acknowledge.
- `CH_POSTED`: valid 1, waiting for the receiver.
- `CH_ACKED`: valid 1, receiver has acknowledged.
- `CH_DRAIN`: valid 0, receiver acknowledge cleared, sender acknowledge still visible.

Transitions:
- post: `CH_IDLE`→`CH_POSTED`, on a transmit control write with bit 0 = 1.
- ack: `CH_POSTED`→`CH_ACKED`, on a receive control write with bit 1 = 1.
- withdraw: `CH_POSTED`→`CH_IDLE`, on a valid write of 0.
- retire: `CH_ACKED`→`CH_DRAIN`, on a valid write of 0.
- settle: `CH_DRAIN`→`CH_IDLE`, always after one cycle.

Top module: `mbx_doorbell`

## Requirements
- R1: After reset every register of both sides reads zero and no interrupt is asserted.
- R2: A word written at address i (0..3) by a side reads back at address i on that side. From the next cycle it also reads at address 4+i on the peer side.
- R3: A transmit control write (address 8) with bit 0 = 1 in `CH_IDLE` sets bit 0 of the sender's transmit control and bit 0 of the peer's receive control (address 9).
- R4: A receive control write with bit 1 = 1 while the peer's channel is `CH_POSTED` sets bit 1 of the receiver's receive control and bit 1 of the sender's transmit control. The write is ignored in any other state, and also in a cycle where the sender writes valid.
- R5: A valid write of 0 in `CH_ACKED` clears the receiver's acknowledge bit in the next cycle while the sender's acknowledge stays 1 for exactly one cycle (`CH_DRAIN`). After that the sender's acknowledge reads 0.
- R6: A valid write of 1 during `CH_DRAIN` is ignored; the channel settles to `CH_IDLE` with valid 0.
- R7: A valid write of 0 in `CH_POSTED` returns the channel to `CH_IDLE` at once, with no acknowledge seen on either side.
- R8: The receiving side's receive interrupt pulses for exactly one cycle after the post transition, only if its interrupt enable bit 0 was set.
- R9: The sending side's acknowledge interrupt pulses for one cycle after the ack transition, only if its interrupt enable bit 1 was set.
- R10: A transmit word write while valid is 1 still stores the word and sets the sticky overwrite bit (transmit control bit 2). The bit holds until a transmit control write with bit 2 = 1. That write also loads valid from its bit 0.
- R11: The two directions are independent: a handshake in one channel does not change the other channel's words, states or interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_wr | input | 1 | Side A write strobe |
| a_addr | input | ADDR_W | Side A register address |
| a_wdata | input | DATA_W | Side A write data |
| a_rdata | output | DATA_W | Side A read data for `a_addr` |
| a_irq_rcv | output | 1 | Side A receive interrupt pulse |
| a_irq_ack | output | 1 | Side A acknowledge interrupt pulse |
| h_wr | input | 1 | Side H write strobe |
| h_addr | input | ADDR_W | Side H register address |
| h_wdata | input | DATA_W | Side H write data |
| h_rdata | output | DATA_W | Side H read data for `h_addr` |
| h_irq_rcv | output | 1 | Side H receive interrupt pulse |
| h_irq_ack | output | 1 | Side H acknowledge interrupt pulse |

## Verification
The hardest situation to reach is `CH_DRAIN`. It lasts a single cycle and exists only after a full post–ack–retire sequence. A directed sequence therefore posts, acknowledges and retires. It then writes valid again in the very next cycle to hit R6. Other collisions need both sides writing in the same cycle, such as an acknowledge landing together with a valid write, or a word write landing on a live message. Long runs of seeded random writes on both ports reach these collisions. Every cycle they are compared against a bench model of the state machine.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_POSTED = 2'd1,
        CH_ACKED  = 2'd2,
        CH_DRAIN  = 2'd3
    } ch_state_e;

    localparam int CTL_VALID = 0;
    localparam int CTL_ACK   = 1;
    localparam int CTL_OVWR  = 2;
    localparam int IEN_RCV   = 0;
    localparam int IEN_ACK   = 1;

endpackage

// File: rtl/mbx_channel.sv
module mbx_channel
    import mbx_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int N_WORDS = 4,
    localparam int WI     = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            word_we,
    input  logic [WI-1:0]                   word_idx,
    input  logic [DATA_W-1:0]               word_data,
    input  logic                            valid_we,
    input  logic                            valid_val,
    input  logic                            ack_we,
    input  logic                            err_clr,
    output logic [N_WORDS-1:0][DATA_W-1:0]  words,
    output logic                            valid,
    output logic                            rx_ack,
    output logic                            tx_ack,
    output logic                            ovwr_err,
    output logic                            evt_post,
    output logic                            evt_ack
);

    ch_state_e state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            CH_IDLE: begin
                if (valid_we && valid_val) state_nxt = CH_POSTED;
            end
            CH_POSTED: begin
                if (valid_we && !valid_val) state_nxt = CH_IDLE;
                else if (!valid_we && ack_we) state_nxt = CH_ACKED;
            end
            CH_ACKED: begin
                if (valid_we && !valid_val) state_nxt = CH_DRAIN;
            end
            CH_DRAIN: state_nxt = CH_IDLE;
            default:  state_nxt = CH_IDLE;
        endcase
    end

    always_comb begin
        valid    = (state == CH_POSTED) || (state == CH_ACKED);
        rx_ack   = (state == CH_ACKED);
        tx_ack   = (state == CH_ACKED) || (state == CH_DRAIN);
        evt_post = (state == CH_IDLE) && (state_nxt == CH_POSTED);
        evt_ack  = (state == CH_POSTED) && (state_nxt == CH_ACKED);
    end

    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) words[g] <= '0;
            else if (word_we && (word_idx == WI'(g))) words[g] <= word_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ovwr_err <= 1'b0;
        else        ovwr_err <= (ovwr_err && !err_clr) || (word_we && valid);
    end

    p_drain_settles_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state == CH_DRAIN |=> state == CH_IDLE);
    p_rxack_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ack |-> valid);
    p_txack_outlives_rxack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_ack) |-> tx_ack && !valid);
    p_overwrite_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        word_we && valid |=> ovwr_err);

endmodule

// File: rtl/mbx_side.sv
module mbx_side
    import mbx_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int N_WORDS = 4,
    parameter int ADDR_W  = 4,
    localparam int WI     = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               wdata,
    input  logic [N_WORDS-1:0][DATA_W-1:0]  tx_words,
    input  logic [N_WORDS-1:0][DATA_W-1:0]  rx_words,
    input  logic                            tx_valid,
    input  logic                            tx_ack,
    input  logic                            tx_err,
    input  logic                            rx_valid,
    input  logic                            rx_ack,
    input  logic                            evt_rx_post,
    input  logic                            evt_tx_ack,
    output logic                            word_we,
    output logic [WI-1:0]                   word_idx,
    output logic                            valid_we,
    output logic                            valid_val,
    output logic                            err_clr,
    output logic                            ack_we,
    output logic [DATA_W-1:0]               rdata,
    output logic                            irq_rcv,
    output logic                            irq_ack
);

    localparam logic [ADDR_W-1:0] A_RXW0 = ADDR_W'(N_WORDS);
    localparam logic [ADDR_W-1:0] A_TXC  = ADDR_W'(2 * N_WORDS);
    localparam logic [ADDR_W-1:0] A_RXC  = ADDR_W'(2 * N_WORDS + 1);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(2 * N_WORDS + 2);

    logic [1:0] ien;

    always_comb begin
        word_we   = wr && (addr < A_RXW0);
        word_idx  = addr[WI-1:0];
        valid_we  = wr && (addr == A_TXC);
        valid_val = wdata[CTL_VALID];
        err_clr   = wr && (addr == A_TXC) && wdata[CTL_OVWR];
        ack_we    = wr && (addr == A_RXC) && wdata[CTL_ACK];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien     <= '0;
            irq_rcv <= 1'b0;
            irq_ack <= 1'b0;
        end else begin
            if (wr && (addr == A_IEN)) ien <= wdata[1:0];
            irq_rcv <= ien[IEN_RCV] && evt_rx_post;
            irq_ack <= ien[IEN_ACK] && evt_tx_ack;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr < A_RXW0)
            rdata = tx_words[addr[WI-1:0]];
        else if (addr < A_TXC)
            rdata = rx_words[addr[WI-1:0]];
        else if (addr == A_TXC)
            rdata = {{(DATA_W-3){1'b0}}, tx_err, tx_ack, tx_valid};
        else if (addr == A_RXC)
            rdata = {{(DATA_W-2){1'b0}}, rx_ack, rx_valid};
        else if (addr == A_IEN)
            rdata = {{(DATA_W-2){1'b0}}, ien};
    end

    p_rcv_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rcv |=> !irq_rcv);
    p_rcv_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rcv |-> $past(ien[IEN_RCV]) && rx_valid);
    p_ack_irq_with_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> tx_ack && $past(ien[IEN_ACK]));

endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
    import mbx_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int N_WORDS = 4,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq_rcv,
    output logic              a_irq_ack,
    input  logic              h_wr,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    output logic              h_irq_rcv,
    output logic              h_irq_ack
);

    localparam int WI = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

    logic                           s_wr    [2];
    logic [ADDR_W-1:0]              s_addr  [2];
    logic [DATA_W-1:0]              s_wdata [2];
    logic [DATA_W-1:0]              s_rdata [2];
    logic                           s_irq_r [2];
    logic                           s_irq_a [2];

    logic [N_WORDS-1:0][DATA_W-1:0] c_words [2];
    logic                           c_valid [2];
    logic                           c_rxack [2];
    logic                           c_txack [2];
    logic                           c_err   [2];
    logic                           c_post  [2];
    logic                           c_ackev [2];
    logic                           c_wwe   [2];
    logic [WI-1:0]                  c_widx  [2];
    logic                           c_vwe   [2];
    logic                           c_vval  [2];
    logic                           c_ackwe [2];
    logic                           c_eclr  [2];

    always_comb begin
        s_wr[0] = a_wr;  s_addr[0] = a_addr;  s_wdata[0] = a_wdata;
        s_wr[1] = h_wr;  s_addr[1] = h_addr;  s_wdata[1] = h_wdata;
        a_rdata = s_rdata[0];  a_irq_rcv = s_irq_r[0];  a_irq_ack = s_irq_a[0];
        h_rdata = s_rdata[1];  h_irq_rcv = s_irq_r[1];  h_irq_ack = s_irq_a[1];
    end

    // Side g sends on channel g and receives on channel 1-g.
    for (genvar g = 0; g < 2; g++) begin : g_dir
        logic ack_from_peer;

        mbx_channel #(.DATA_W(DATA_W), .N_WORDS(N_WORDS)) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .word_we  (c_wwe[g]),
            .word_idx (c_widx[g]),
            .word_data(s_wdata[g]),
            .valid_we (c_vwe[g]),
            .valid_val(c_vval[g]),
            .ack_we   (ack_from_peer),
            .err_clr  (c_eclr[g]),
            .words    (c_words[g]),
            .valid    (c_valid[g]),
            .rx_ack   (c_rxack[g]),
            .tx_ack   (c_txack[g]),
            .ovwr_err (c_err[g]),
            .evt_post (c_post[g]),
            .evt_ack  (c_ackev[g])
        );

        assign ack_from_peer = c_ackwe[1-g];

        mbx_side #(.DATA_W(DATA_W), .N_WORDS(N_WORDS), .ADDR_W(ADDR_W)) i_side (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr         (s_wr[g]),
            .addr       (s_addr[g]),
            .wdata      (s_wdata[g]),
            .tx_words   (c_words[g]),
            .rx_words   (c_words[1-g]),
            .tx_valid   (c_valid[g]),
            .tx_ack     (c_txack[g]),
            .tx_err     (c_err[g]),
            .rx_valid   (c_valid[1-g]),
            .rx_ack     (c_rxack[1-g]),
            .evt_rx_post(c_post[1-g]),
            .evt_tx_ack (c_ackev[g]),
            .word_we    (c_wwe[g]),
            .word_idx   (c_widx[g]),
            .valid_we   (c_vwe[g]),
            .valid_val  (c_vval[g]),
            .err_clr    (c_eclr[g]),
            .ack_we     (c_ackwe[g]),
            .rdata      (s_rdata[g]),
            .irq_rcv    (s_irq_r[g]),
            .irq_ack    (s_irq_a[g])
        );
    end

endmodule

// File: tb/test_mbx_doorbell.sv
`timescale 1ns/1ps
module test_mbx_doorbell;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_wr = 1'b0, h_wr = 1'b0;
    logic [3:0]  a_addr = '0, h_addr = '0;
    logic [31:0] a_wdata = '0, h_wdata = '0;
    logic [31:0] a_rdata, h_rdata;
    logic        a_irq_rcv, a_irq_ack, h_irq_rcv, h_irq_ack;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model: st 0 idle, 1 posted, 2 acked, 3 drain
    int          st [2];
    logic [31:0] wd [2][4];
    bit          er [2];
    bit [1:0]    en [2];
    bit          x_irq_r [2];
    bit          x_irq_a [2];

    always #2.5 clk = ~clk;

    mbx_doorbell i_mbx_doorbell (
        .clk(clk), .rst_n(rst_n),
        .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .a_irq_rcv(a_irq_rcv), .a_irq_ack(a_irq_ack),
        .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .h_irq_rcv(h_irq_rcv), .h_irq_ack(h_irq_ack)
    );

    function automatic logic [31:0] exp_rd(input int s, input logic [3:0] ad);
        int p = 1 - s;
        if (ad < 4)   return wd[s][ad[1:0]];
        if (ad < 8)   return wd[p][ad[1:0]];
        if (ad == 8)  return {29'd0, er[s], (st[s] == 2 || st[s] == 3), (st[s] == 1 || st[s] == 2)};
        if (ad == 9)  return {30'd0, (st[p] == 2), (st[p] == 1 || st[p] == 2)};
        if (ad == 10) return {30'd0, en[s]};
        return 32'd0;
    endfunction

    function automatic int next_st(input int cur, input bit vwe, input bit vv, input bit ackw);
        if (cur == 3) return 0;
        if (vwe && !vv) return (cur == 2) ? 3 : ((cur == 1) ? 0 : cur);
        if (vwe && vv && cur == 0) return 1;
        if (!vwe && ackw && cur == 1) return 2;
        return cur;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit aw, input logic [3:0] aa, input logic [31:0] ad,
                        input bit hw, input logic [3:0] ha, input logic [31:0] hd,
                        input string tag);
        bit w [2];
        logic [3:0] a [2];
        logic [31:0] d [2];
        int nx [2];
        w[0] = aw; a[0] = aa; d[0] = ad;
        w[1] = hw; a[1] = ha; d[1] = hd;
        a_wr = aw; a_addr = aa; a_wdata = ad;
        h_wr = hw; h_addr = ha; h_wdata = hd;
        @(posedge clk);
        for (int c = 0; c < 2; c++) begin
            int r = 1 - c;
            bit vwe  = w[c] && a[c] == 8;
            bit ackw = w[r] && a[r] == 9 && d[r][1];
            bit vld  = (st[c] == 1 || st[c] == 2);
            nx[c] = next_st(st[c], vwe, d[c][0], ackw);
            x_irq_r[r] = en[r][0] && st[c] == 0 && nx[c] == 1;
            x_irq_a[c] = en[c][1] && st[c] == 1 && nx[c] == 2;
            er[c] = (er[c] && !(vwe && d[c][2])) || (w[c] && a[c] < 4 && vld);
            if (w[c] && a[c] < 4) wd[c][a[c][1:0]] = d[c];
        end
        for (int s = 0; s < 2; s++) begin
            st[s] = nx[s];
            if (w[s] && a[s] == 10) en[s] = d[s][1:0];
        end
        @(negedge clk);
        check(tag, "a_rdata", a_rdata, exp_rd(0, aa));
        check(tag, "h_rdata", h_rdata, exp_rd(1, ha));
        check(tag, "irq_rcv a/h", {30'd0, a_irq_rcv, h_irq_rcv}, {30'd0, x_irq_r[0], x_irq_r[1]});
        check(tag, "irq_ack a/h", {30'd0, a_irq_ack, h_irq_ack}, {30'd0, x_irq_a[0], x_irq_a[1]});
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            st[s] = 0; er[s] = 0; en[s] = 0; x_irq_r[s] = 0; x_irq_a[s] = 0;
            for (int i = 0; i < 4; i++) wd[s][i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: every register reads zero after reset
        for (int i = 0; i < 12; i++) step(0, 4'(i), 0, 0, 4'(i), 0, "R1");
        // R8/R9: enable both interrupts on both sides
        step(1, 10, 32'h3, 1, 10, 32'h3, "R8");
        // R2: A fills its words, H sees them in its receive window
        for (int i = 0; i < 4; i++) step(1, 4'(i), 32'hA5A0_0000 + 32'(i), 0, 4'(4 + i), 0, "R2");
        for (int i = 0; i < 4; i++) step(0, 4'(i), 0, 0, 4'(4 + i), 0, "R2");
        // R3/R8: A posts, H gets a receive pulse
        step(1, 8, 32'h1, 0, 9, 0, "R3");
        step(0, 8, 0, 0, 9, 0, "R8");
        // R10: overwrite while valid is flagged and the word is still stored
        step(1, 1, 32'hDEAD_BEEF, 0, 5, 0, "R10");
        step(0, 8, 0, 0, 5, 0, "R10");
        // R4/R9: H acknowledges
        step(0, 8, 0, 1, 9, 32'h2, "R4");
        step(0, 8, 0, 0, 9, 0, "R9");
        // R5: retire, drain for one cycle; R6: valid write during drain ignored
        step(1, 8, 32'h0, 0, 9, 0, "R5");
        step(1, 8, 32'h1, 0, 9, 0, "R6");
        step(0, 8, 0, 0, 9, 0, "R6");
        // R7: post then withdraw; R4: stray ack in idle ignored
        step(1, 8, 32'h1, 0, 9, 0, "R7");
        step(1, 8, 32'h0, 0, 9, 0, "R7");
        step(0, 8, 0, 1, 9, 32'h2, "R4");
        step(0, 8, 0, 0, 9, 0, "R4");
        // R4: ack in the same cycle the sender re-writes valid is dropped
        step(1, 8, 32'h1, 0, 9, 0, "R4");
        step(1, 8, 32'h1, 1, 9, 32'h2, "R4");
        step(1, 8, 32'h0, 0, 9, 0, "R7");
        // R8/R11: A masks its receive interrupt, H posts in the other channel
        step(1, 10, 32'h2, 1, 0, 32'h1234_5678, "R11");
        step(0, 4, 0, 1, 8, 32'h1, "R8");
        step(1, 9, 32'h2, 0, 8, 0, "R11");
        step(0, 8, 0, 0, 8, 0, "R11");
        step(0, 9, 0, 1, 8, 32'h0, "R5");
        step(0, 9, 0, 0, 8, 0, "R5");
        // R10: write-1-to-clear of the overwrite flag
        step(1, 8, 32'h4, 0, 0, 0, "R10");
        step(0, 8, 0, 0, 0, 0, "R10");

        // seeded random traffic on both ports (R2..R11 via model)
        void'($urandom(32'h5EED_0C0B));
        for (int n = 0; n < 4000; n++) begin
            bit aw = ($urandom_range(0, 2) != 0);
            bit hw = ($urandom_range(0, 2) != 0);
            logic [3:0] aa = 4'($urandom_range(0, 11));
            logic [3:0] ha = 4'($urandom_range(0, 11));
            logic [31:0] ad = $urandom();
            logic [31:0] hd = $urandom();
            step(aw, aa, ad, hw, ha, hd, "RND");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule